// File: doc/BRIEF.md
# Receiver Hunt and Status-Change Latch

This block sits beside a synchronous serial receiver and keeps two kinds of state. The first is the receiver's Hunt bit, which says whether the receiver is still searching for character or frame alignment. The rules that move the Hunt bit depend on the framing mode:

- In byte-sync mode, Hunt moves only on host commands and sync matches.
- In bit-oriented (flag-delimited) mode, Hunt also reacts to aborts, flags and the receiver being switched on.

The second is a small readable status word holding three bits: Hunt, transmit underrun/end-of-message and zero-count. A change detector watches the live values behind this word. When a change that warrants attention occurs while the status word is open, the word freezes with the new values and an external/status interrupt request is raised. The word stays frozen until the host issues a Reset Ext/Status command. Both directions of a Hunt change freeze the word. Clearing the underrun bit by its own reset command updates the word quietly.

Host software reads the status word when the interrupt is seen and compares it against its own copy. It then issues Reset Ext/Status to reopen the word. If anything moved while the word was frozen, the word freezes again on the following cycle, so no change is lost.

Top module: `hunt_status_latch`

## Requirements
- R1: During and after a synchronous active-low reset, statHunt, statEom, statZeroCnt and extStatIrq all read 0 and the status word is open.
- R2: In byte-sync mode (bitMode=0), enterHunt sets the internal Hunt state and syncMatch clears it. flagSeen, abortSeen and a rising edge of rxEnable leave it unchanged.
- R3: In bit-oriented mode (bitMode=1), enterHunt, abortSeen or a rising edge of rxEnable (1 now, 0 on the previous cycle) sets Hunt, and flagSeen clears it. syncMatch leaves it unchanged.
- R4: When a set cause and a clear cause for Hunt occur in the same cycle, Hunt ends up set.
- R5: With the word open, a Hunt change in either direction appears on statHunt one clock after the internal Hunt state changes, that is two clocks after the causing strobe. In that same clock, extStatIrq rises.
- R6: While extStatIrq is high and no Reset Ext/Status is given, all three status outputs and extStatIrq hold their values whatever the inputs do.
- R7: resetExtStat deasserts extStatIrq and reopens the word at the next clock, and statZeroCnt reads 0 after that clock. It takes priority over a change captured in the same cycle.
- R8: After a reopen, if the live Hunt or underrun state differs from the frozen word in a way that warrants attention, the word captures the live values and extStatIrq rises one clock later.
- R9: A txUnderrun pulse sets the underrun/EOM state. With the word open, the state shows on statEom one clock later, with extStatIrq. resetUnderrun clears the state, and the word then follows it without raising extStatIrq. txUnderrun wins over resetUnderrun in the same cycle.
- R10: With the word open, a zeroCountIn high is captured on statZeroCnt at the next clock, and extStatIrq rises in the same clock. A falling zeroCountIn raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| bitMode | input | 1 | 0 = byte-sync framing, 1 = bit-oriented flag framing |
| rxEnable | input | 1 | Receiver enable level |
| enterHunt | input | 1 | Enter Hunt command strobe |
| syncMatch | input | 1 | Sync character matched pulse |
| flagSeen | input | 1 | Flag received pulse |
| abortSeen | input | 1 | Abort sequence received pulse |
| zeroCountIn | input | 1 | Baud counter zero-count pulse |
| txUnderrun | input | 1 | Transmit underrun/EOM event pulse |
| resetUnderrun | input | 1 | Reset underrun/EOM latch command strobe |
| resetExtStat | input | 1 | Reset Ext/Status command strobe |
| statHunt | output | 1 | Readable Hunt status bit |
| statEom | output | 1 | Readable underrun/EOM status bit |
| statZeroCnt | output | 1 | Readable zero-count status bit |
| extStatIrq | output | 1 | External/status interrupt request |

## Verification
A wrong internal Hunt state cannot hide. Within two clocks of the causing strobe it either produces an interrupt that should not happen or misses one that should. If the freeze control is wrong, the status outputs drift while extStatIrq is high, or a change made during the frozen window fails to re-raise the interrupt one clock after the reopen. A reference model in the bench is compared against all four outputs after every clock, so any divergence is reported in the cycle it first shows at the ports.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_BIT  = 1'b1
  } frameMode_e;

  // strobes from control to the status datapath
  typedef struct packed {
    logic capture;  // load live values and freeze
    logic follow;   // load live values, stay open
    logic reopen;   // reopen command: clear zero-count bit
  } latchStrobe_t;

endpackage

// File: rtl/hsl_ctrl.sv
module hsl_ctrl
  import hsl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  frameMode_e   mode,
  input  logic         rxEnable,
  input  logic         enterHunt,
  input  logic         syncMatch,
  input  logic         flagSeen,
  input  logic         abortSeen,
  input  logic         resetExtStat,
  input  logic         changeSeen,
  output logic         huntLive,
  output latchStrobe_t strobe,
  output logic         irq
);

  logic rxEnPrev;
  logic latchOpen;
  logic rxRise;
  logic huntSet;
  logic huntClr;

  always_comb begin
    rxRise  = rxEnable && !rxEnPrev;
    huntSet = enterHunt || ((mode == MODE_BIT) && (abortSeen || rxRise));
    huntClr = (mode == MODE_BIT) ? flagSeen : syncMatch;
  end

  always_comb begin
    strobe.reopen  = resetExtStat;
    strobe.capture = !resetExtStat && latchOpen && changeSeen;
    strobe.follow  = !resetExtStat && latchOpen && !changeSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      huntLive  <= 1'b0;
      rxEnPrev  <= 1'b0;
      latchOpen <= 1'b1;
      irq       <= 1'b0;
    end else begin
      rxEnPrev <= rxEnable;
      if (huntSet)      huntLive <= 1'b1;
      else if (huntClr) huntLive <= 1'b0;
      if (resetExtStat) begin
        latchOpen <= 1'b1;
        irq       <= 1'b0;
      end else if (latchOpen && changeSeen) begin
        latchOpen <= 1'b0;
        irq       <= 1'b1;
      end
    end
  end

  AST_BYTE_NO_AUTO_HUNT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BYTE && !enterHunt && !huntLive) |=> !huntLive); // R2

  AST_FLAG_CLEARS_HUNT: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_BIT && flagSeen && !enterHunt && !abortSeen && !rxRise) |=> !huntLive); // R3

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (enterHunt && (syncMatch || flagSeen)) |=> huntLive); // R4

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !resetExtStat) |=> irq); // R6

  AST_RESET_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    resetExtStat |=> !irq); // R7

endmodule

// File: rtl/hsl_datapath.sv
module hsl_datapath
  import hsl_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         huntLive,
  input  logic         zeroCountIn,
  input  logic         txUnderrun,
  input  logic         resetUnderrun,
  input  latchStrobe_t strobe,
  output logic         changeSeen,
  output logic         statHunt,
  output logic         statEom,
  output logic         statZeroCnt
);

  logic eomLive;

  // any Hunt edge, and rising edges of underrun and zero-count, warrant an interrupt
  always_comb begin
    changeSeen = (huntLive != statHunt)
              || (eomLive && !statEom)
              || (zeroCountIn && !statZeroCnt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eomLive <= 1'b0;
    end else if (txUnderrun) begin
      eomLive <= 1'b1;
    end else if (resetUnderrun) begin
      eomLive <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statHunt    <= 1'b0;
      statEom     <= 1'b0;
      statZeroCnt <= 1'b0;
    end else if (strobe.reopen) begin
      statZeroCnt <= 1'b0;
    end else if (strobe.capture || strobe.follow) begin
      statHunt    <= huntLive;
      statEom     <= eomLive;
      statZeroCnt <= zeroCountIn;
    end
  end

  AST_ZC_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reopen |=> !statZeroCnt); // R7

  AST_EOM_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    txUnderrun |=> eomLive); // R9

  AST_EOM_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (resetUnderrun && !txUnderrun) |=> !eomLive); // R9

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capture, strobe.follow, strobe.reopen})); // R7

endmodule

// File: rtl/hunt_status_latch.sv
module hunt_status_latch
  import hsl_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic bitMode,
  input  logic rxEnable,
  input  logic enterHunt,
  input  logic syncMatch,
  input  logic flagSeen,
  input  logic abortSeen,
  input  logic zeroCountIn,
  input  logic txUnderrun,
  input  logic resetUnderrun,
  input  logic resetExtStat,
  output logic statHunt,
  output logic statEom,
  output logic statZeroCnt,
  output logic extStatIrq
);

  latchStrobe_t strobe;
  logic         huntLive;
  logic         changeSeen;

  hsl_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .mode         (frameMode_e'(bitMode)),
    .rxEnable     (rxEnable),
    .enterHunt    (enterHunt),
    .syncMatch    (syncMatch),
    .flagSeen     (flagSeen),
    .abortSeen    (abortSeen),
    .resetExtStat (resetExtStat),
    .changeSeen   (changeSeen),
    .huntLive     (huntLive),
    .strobe       (strobe),
    .irq          (extStatIrq)
  );

  hsl_datapath u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .huntLive      (huntLive),
    .zeroCountIn   (zeroCountIn),
    .txUnderrun    (txUnderrun),
    .resetUnderrun (resetUnderrun),
    .strobe        (strobe),
    .changeSeen    (changeSeen),
    .statHunt      (statHunt),
    .statEom       (statEom),
    .statZeroCnt   (statZeroCnt)
  );

  AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (extStatIrq && !resetExtStat) |=> $stable({statHunt, statEom, statZeroCnt})); // R6

  AST_UNDERRUN_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!extStatIrq && resetUnderrun && !txUnderrun && !resetExtStat && !enterHunt
     && !syncMatch && !flagSeen && !abortSeen && !rxEnable && !zeroCountIn
     && $stable(statHunt)) |=> !$rose(extStatIrq) || $changed(statHunt) || statZeroCnt || statEom); // R9

endmodule

// File: tb/hunt_status_latch_bench.sv
module hunt_status_latch_bench;

  logic clk = 1'b0;
  logic rstN, bitMode, rxEnable, enterHunt, syncMatch, flagSeen, abortSeen;
  logic zeroCountIn, txUnderrun, resetUnderrun, resetExtStat;
  logic statHunt, statEom, statZeroCnt, extStatIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state, meaning: values after the next clock edge
  bit mHunt, mPrevEn, mOpen, mIrq, mEom, sHunt, sEom, sZc;

  always #4 clk = ~clk;

  hunt_status_latch u_hunt_status_latch (
    .clk(clk), .rstN(rstN), .bitMode(bitMode), .rxEnable(rxEnable),
    .enterHunt(enterHunt), .syncMatch(syncMatch), .flagSeen(flagSeen),
    .abortSeen(abortSeen), .zeroCountIn(zeroCountIn), .txUnderrun(txUnderrun),
    .resetUnderrun(resetUnderrun), .resetExtStat(resetExtStat),
    .statHunt(statHunt), .statEom(statEom), .statZeroCnt(statZeroCnt),
    .extStatIrq(extStatIrq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelStep();
    bit rise, hSet, hClr, trig, nHunt, nEom;
    if (!rstN) begin
      mHunt = 0; mPrevEn = 0; mOpen = 1; mIrq = 0; mEom = 0;
      sHunt = 0; sEom = 0; sZc = 0;
      return;
    end
    rise  = rxEnable && !mPrevEn;
    hSet  = enterHunt || (bitMode && (abortSeen || rise));
    hClr  = bitMode ? flagSeen : syncMatch;
    nHunt = hSet ? 1'b1 : (hClr ? 1'b0 : mHunt);
    nEom  = txUnderrun ? 1'b1 : (resetUnderrun ? 1'b0 : mEom);
    trig  = (mHunt != sHunt) || (mEom && !sEom) || (zeroCountIn && !sZc);
    if (resetExtStat) begin
      mOpen = 1; mIrq = 0; sZc = 0;
    end else if (mOpen) begin
      sHunt = mHunt; sEom = mEom; sZc = zeroCountIn;
      if (trig) begin mOpen = 0; mIrq = 1; end
    end
    mHunt = nHunt; mEom = nEom; mPrevEn = rxEnable;
  endfunction

  task automatic clearStrobes();
    enterHunt = 0; syncMatch = 0; flagSeen = 0; abortSeen = 0;
    zeroCountIn = 0; txUnderrun = 0; resetUnderrun = 0; resetExtStat = 0;
  endtask

  task automatic step();
    string tag;
    modelStep();
    @(posedge clk);
    #2;
    tag = mOpen ? "R5" : "R6";
    chk(tag, statHunt, sHunt);
    chk(tag, statEom, sEom);
    chk(tag, statZeroCnt, sZc);
    chk(tag, extStatIrq, mIrq);
    clearStrobes();
  endtask

  task automatic reopen();
    resetExtStat = 1; step(); step();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rstN = 0; bitMode = 0; rxEnable = 0; clearStrobes();
    step(); step(); step();
    chk("R1", statHunt, 0); chk("R1", statEom, 0);
    chk("R1", statZeroCnt, 0); chk("R1", extStatIrq, 0);
    rstN = 1; step();

    // byte-sync mode
    enterHunt = 1; step(); chk("R5", extStatIrq, 0);
    step(); chk("R2", statHunt, 1); chk("R5", extStatIrq, 1);
    syncMatch = 1; step(); step(); chk("R6", statHunt, 1); chk("R6", extStatIrq, 1);
    resetExtStat = 1; step(); chk("R7", extStatIrq, 0); chk("R7", statZeroCnt, 0);
    step(); chk("R8", statHunt, 0); chk("R8", extStatIrq, 1);
    reopen(); chk("R7", extStatIrq, 0);
    abortSeen = 1; step(); flagSeen = 1; step(); rxEnable = 1; step(); step();
    chk("R2", statHunt, 0); chk("R2", extStatIrq, 0);

    // bit-oriented mode
    bitMode = 1; rxEnable = 0; step(); step();
    rxEnable = 1; step(); step();
    chk("R3", statHunt, 1); chk("R3", extStatIrq, 1);
    reopen(); chk("R7", extStatIrq, 0);
    flagSeen = 1; step(); step(); chk("R3", statHunt, 0); chk("R3", extStatIrq, 1);
    reopen();
    abortSeen = 1; step(); step(); chk("R3", statHunt, 1); chk("R3", extStatIrq, 1);
    reopen();
    syncMatch = 1; step(); step(); chk("R3", statHunt, 1); chk("R3", extStatIrq, 0);
    flagSeen = 1; abortSeen = 1; step(); step();
    chk("R4", statHunt, 1); chk("R4", extStatIrq, 0);
    bitMode = 0; syncMatch = 1; enterHunt = 1; step(); step();
    chk("R4", statHunt, 1); chk("R4", extStatIrq, 0);

    // underrun / EOM
    txUnderrun = 1; step(); step(); chk("R9", statEom, 1); chk("R9", extStatIrq, 1);
    reopen();
    resetUnderrun = 1; step(); step(); chk("R9", statEom, 0); chk("R9", extStatIrq, 0);
    txUnderrun = 1; resetUnderrun = 1; step(); step();
    chk("R9", statEom, 1); chk("R9", extStatIrq, 1);
    reopen(); resetUnderrun = 1; step(); step();

    // zero count
    zeroCountIn = 1; step(); chk("R10", statZeroCnt, 1); chk("R10", extStatIrq, 1);
    resetExtStat = 1; step(); chk("R7", statZeroCnt, 0);
    step(); chk("R10", extStatIrq, 0);
    zeroCountIn = 1; resetExtStat = 1; step(); chk("R7", extStatIrq, 0);

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 63) == 0) bitMode = ~bitMode;
      if ($urandom_range(0, 15) == 0) rxEnable = ~rxEnable;
      enterHunt     = ($urandom_range(0, 9) == 0);
      syncMatch     = ($urandom_range(0, 7) == 0);
      flagSeen      = ($urandom_range(0, 7) == 0);
      abortSeen     = ($urandom_range(0, 11) == 0);
      zeroCountIn   = ($urandom_range(0, 11) == 0);
      txUnderrun    = ($urandom_range(0, 13) == 0);
      resetUnderrun = ($urandom_range(0, 7) == 0);
      resetExtStat  = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 499) == 0) rstN = 0; else rstN = 1;
      step();
      if (!rstN) begin
        chk("R1", extStatIrq, 0); chk("R1", statHunt, 0);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule